// File: doc/BRIEF.md
# Set-Associative Block Cache with Selectable Write Policy

This block is a word-organised, set-associative cache placed between a simple processor request port and a backing memory that moves one word per handshake. A byte address is reduced to a word address and split into a column within the block, a row selecting the set, and a tag. All ways of the selected row are searched. A miss always loads the whole block, whether the access reads or writes. Before the fill, a dirty victim is copied back to memory when the write-back policy is active. Under the write-through policy every store is also sent to memory, and lines are never marked dirty.

Two commands act on the whole cache. Flush walks every line, writes back the dirty ones and invalidates them all. Invalidate-all drops every line without any memory traffic and clears the hit and miss statistics. The way count, set count and block length are parameters, and each must be a power of two of at least 2. Victims come from a per-row round-robin selector that is kept in a module of its own.

Top module: `sa_wb_cache`

## Requirements
- R1: The word address is the byte address with its two low bits dropped. The column is its low log2(WORDS) bits, the row is the next log2(SETS) bits and the tag is the rest. A fill reads the block at byte addresses ((tag·WORDS·SETS)+row·WORDS)·4 + 4·k for k = 0..WORDS-1, in rising order.
- R2: Lookup picks the lowest-numbered way of the row that is either invalid or valid with an equal tag. The access counts as a hit only if that way is valid.
- R3: A victim is requested only when every way of the row is valid and none matches. Each row has a round-robin pointer that starts at way 0 after `rst` and steps by one, wrapping, each time that row supplies a victim.
- R4: On a miss, read or write, exactly WORDS memory reads fill the line. The line then holds the new tag and is valid. A read miss returns the word that memory held.
- R5: A hit makes no memory read. A read hit returns the word most recently stored at that address through the cache.
- R6: With `wb_policy`=1, a store marks its line dirty. Evicting a dirty line writes all WORDS words to the address built from that line's stored tag, before the fill. A clean line is never written back.
- R7: With `wb_policy`=0, each store performs exactly one memory write of the stored word at its own address before the response, and leaves the line clean.
- R8: A flush (`flush_req` while idle) writes back every dirty valid line when `wb_policy`=1 and invalidates all lines, so the next access misses.
- R9: Invalidate-all (`inval_req` while idle, which takes priority over flush and requests) clears every line and both counters in one cycle with no memory write.
- R10: `hit_count` and `miss_count` are 32-bit counters, zero after `rst`. Each access adds one to exactly one of them, and they wrap on overflow.
- R11: `req_ready` is high only while idle with no command asserted. `busy` is high from the accepted request or command until completion. `rsp_valid` is a one-cycle pulse whose `rsp_rdata` is the read word, or the stored word for a write. A memory request keeps its address, direction and data until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_policy | input | 1 | 1 = write-back, 0 = write-through; hold stable while busy |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Loaded word, or stored word for a write |
| flush_req | input | 1 | Write back dirty lines and invalidate all |
| inval_req | input | 1 | Invalidate all and clear counters, no write-back |
| busy | output | 1 | An operation is in progress |
| mem_valid | output | 1 | Memory word transfer requested |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| hit_count | output | 32 | Hit statistic |
| miss_count | output | 32 | Miss statistic |

## Verification
A wrong tag, valid or dirty bit does not stay hidden. It turns a hit into a miss, or a miss into a hit, and this shows in the very next response as a counter step and a fill burst that should or should not be there. A stale or misplaced data word appears as a load miscompare as soon as that address is read. A wrong victim pointer or a lost dirty bit first appears as a missing or extra write-back burst. Its corrupting effect on memory only comes out at the next flush, which is why every flush is followed by a full comparison of backing memory against the arithmetic model.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_TAG, S_WB_RD, S_WB_WR, S_FILL,
    S_ACCESS, S_WT, S_RESP, S_FL_CHK, S_FL_NXT
  } cache_state_e;
endpackage

// File: rtl/cache_way_search.sv
`timescale 1ns/1ps
module cache_way_search #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 24,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic                       found,
  output logic [WAY_W-1:0]           way,
  output logic                       hit
);
  // Scan downward so the lowest qualifying way is the last one assigned.
  always_comb begin
    found = 1'b0;
    way   = '0;
    hit   = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i] || tags[i] == tag) begin
        found = 1'b1;
        way   = WAY_W'(i);
        hit   = valid[i];
      end
    end
  end
endmodule

// File: rtl/cache_victim_rr.sv
`timescale 1ns/1ps
module cache_victim_rr #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int WAY_W = 1,
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] row,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);
  logic [SETS-1:0][WAY_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q[row] <= (ptr_q[row] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[row] + 1'b1;
    end
  end

  assign victim = ptr_q[row];
endmodule

// File: rtl/cache_data_ram.sv
`timescale 1ns/1ps
module cache_data_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sa_wb_cache.sv
`timescale 1ns/1ps
module sa_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_policy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              flush_req,
  input  logic              inval_req,
  output logic              busy,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [31:0]       hit_count,
  output logic [31:0]       miss_count
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ROW_W = $clog2(SETS);
  localparam int COL_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - 2 - ROW_W - COL_W;
  localparam int IDX_W = WAY_W + ROW_W + COL_W;
  localparam int FL_W  = WAY_W + ROW_W;
  localparam int DEPTH = WAYS * SETS * WORDS;

  cache_state_e state;
  logic              r_write, r_flush;
  logic [DATA_W-1:0] r_wdata;
  logic [TAG_W-1:0]  r_tag, v_tag;
  logic [ROW_W-1:0]  r_row, v_row;
  logic [COL_W-1:0]  r_col, beat;
  logic [WAY_W-1:0]  v_way;
  logic [FL_W-1:0]   fl_idx;
  logic [31:0]       hit_q, miss_q;

  logic [SETS-1:0][WAYS-1:0]            valid_q, dirty_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;

  logic             s_found, s_hit;
  logic [WAY_W-1:0] s_way, vic_way, way_sel, fl_way;
  logic [ROW_W-1:0] fl_row;
  logic             last_beat;

  assign fl_way    = fl_idx[FL_W-1 -: WAY_W];
  assign fl_row    = fl_idx[ROW_W-1:0];
  assign way_sel   = s_found ? s_way : vic_way;
  assign last_beat = (beat == COL_W'(WORDS - 1));

  cache_way_search #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_search (
    .valid(valid_q[r_row]), .tags(tag_q[r_row]), .tag(r_tag),
    .found(s_found), .way(s_way), .hit(s_hit)
  );

  cache_victim_rr #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .ROW_W(ROW_W)) u_victim (
    .clk(clk), .rst(rst), .row(r_row),
    .advance(state == S_TAG && !s_found), .victim(vic_way)
  );

  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  assign ram_we    = (state == S_FILL && mem_ready) || (state == S_ACCESS && r_write);
  assign ram_waddr = (state == S_FILL) ? {v_way, v_row, beat} : {v_way, v_row, r_col};
  assign ram_wdata = (state == S_FILL) ? mem_rdata : r_wdata;
  assign ram_raddr = (state == S_WB_RD || state == S_WB_WR) ? {v_way, v_row, beat}
                                                             : {v_way, v_row, r_col};

  cache_data_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
      hit_q   <= '0;
      miss_q  <= '0;
      r_flush <= 1'b0;
      r_write <= 1'b0;
      r_wdata <= '0;
      r_tag   <= '0;
      r_row   <= '0;
      r_col   <= '0;
      v_tag   <= '0;
      v_row   <= '0;
      v_way   <= '0;
      beat    <= '0;
      fl_idx  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (inval_req) begin
            valid_q <= '0;
            dirty_q <= '0;
            hit_q   <= '0;
            miss_q  <= '0;
          end else if (flush_req) begin
            fl_idx  <= '0;
            r_flush <= 1'b1;
            state   <= S_FL_CHK;
          end else if (req_valid) begin
            r_write <= req_write;
            r_wdata <= req_wdata;
            r_col   <= req_addr[2 +: COL_W];
            r_row   <= req_addr[2 + COL_W +: ROW_W];
            r_tag   <= req_addr[ADDR_W-1 -: TAG_W];
            r_flush <= 1'b0;
            state   <= S_TAG;
          end
        end
        S_TAG: begin
          v_way <= way_sel;
          v_row <= r_row;
          v_tag <= tag_q[r_row][way_sel];
          beat  <= '0;
          if (s_hit) begin
            hit_q <= hit_q + 32'd1;
            state <= S_ACCESS;
          end else begin
            miss_q <= miss_q + 32'd1;
            if (!s_found && dirty_q[r_row][vic_way] && wb_policy) begin
              state <= S_WB_RD;
            end else begin
              valid_q[r_row][way_sel] <= 1'b0;
              dirty_q[r_row][way_sel] <= 1'b0;
              state <= S_FILL;
            end
          end
        end
        S_WB_RD: state <= S_WB_WR;
        S_WB_WR: begin
          if (mem_ready) begin
            if (last_beat) begin
              beat <= '0;
              if (r_flush) begin
                state <= S_FL_NXT;
              end else begin
                valid_q[v_row][v_way] <= 1'b0;
                dirty_q[v_row][v_way] <= 1'b0;
                state <= S_FILL;
              end
            end else begin
              beat  <= beat + 1'b1;
              state <= S_WB_RD;
            end
          end
        end
        S_FILL: begin
          if (mem_ready) begin
            if (last_beat) begin
              valid_q[v_row][v_way] <= 1'b1;
              dirty_q[v_row][v_way] <= 1'b0;
              tag_q[v_row][v_way]   <= r_tag;
              beat  <= '0;
              state <= S_ACCESS;
            end else begin
              beat <= beat + 1'b1;
            end
          end
        end
        S_ACCESS: begin
          if (r_write) begin
            dirty_q[v_row][v_way] <= wb_policy;
            state <= wb_policy ? S_RESP : S_WT;
          end else begin
            state <= S_RESP;
          end
        end
        S_WT:   if (mem_ready) state <= S_RESP;
        S_RESP: state <= S_IDLE;
        S_FL_CHK: begin
          v_way <= fl_way;
          v_row <= fl_row;
          v_tag <= tag_q[fl_row][fl_way];
          beat  <= '0;
          if (valid_q[fl_row][fl_way] && dirty_q[fl_row][fl_way] && wb_policy)
            state <= S_WB_RD;
          else
            state <= S_FL_NXT;
        end
        S_FL_NXT: begin
          valid_q[fl_row][fl_way] <= 1'b0;
          dirty_q[fl_row][fl_way] <= 1'b0;
          if (fl_idx == {FL_W{1'b1}}) begin
            r_flush <= 1'b0;
            state   <= S_IDLE;
          end else begin
            fl_idx <= fl_idx + 1'b1;
            state  <= S_FL_CHK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign req_ready  = (state == S_IDLE) && !inval_req && !flush_req;
  assign rsp_valid  = (state == S_RESP);
  assign rsp_rdata  = r_write ? r_wdata : ram_q;
  assign mem_valid  = (state == S_WB_WR) || (state == S_FILL) || (state == S_WT);
  assign mem_write  = (state == S_WB_WR) || (state == S_WT);
  assign mem_wdata  = (state == S_WB_WR) ? ram_q : r_wdata;
  assign hit_count  = hit_q;
  assign miss_count = miss_q;

  always_comb begin
    case (state)
      S_WB_WR: mem_addr = {v_tag, v_row, beat, 2'b00};
      S_FILL:  mem_addr = {r_tag, v_row, beat, 2'b00};
      default: mem_addr = {r_tag, r_row, r_col, 2'b00};
    endcase
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata))); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11
  AST_VICTIM_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (state == S_TAG && !s_found) |-> (&valid_q[r_row])); // R3
  AST_WB_NEEDS_POLICY: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB_WR) |-> wb_policy); // R6
  AST_WT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACCESS && r_write && !wb_policy) |=> !dirty_q[v_row][v_way]); // R7
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && inval_req) |=> (valid_q == '0 && hit_q == 32'd0 && miss_q == 32'd0)); // R9
  AST_COUNT_ONLY_AT_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    (state != S_TAG && !(state == S_IDLE && inval_req)) |=> ($stable(hit_q) && $stable(miss_q))); // R10
endmodule

// File: tb/sa_wb_cache_test.sv
`timescale 1ns/1ps
module sa_wb_cache_test;
  localparam int WAYS = 2, SETS = 4, WORDS = 4;
  localparam int SPAN = WAYS * SETS * WORDS * 2; // 64 words exercised

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        wb_policy = 1'b1, req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        flush_req = 1'b0, inval_req = 1'b0;
  logic        req_ready, rsp_valid, busy, mem_valid, mem_write;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata, hit_count, miss_count;
  logic        mem_ready = 1'b1;

  sa_wb_cache #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) uut (
    .clk(clk), .rst(rst), .wb_policy(wb_policy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .flush_req(flush_req), .inval_req(inval_req), .busy(busy),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // Backing memory model
  logic [31:0] bmem [0:1023];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] fill_base = '0;
  assign mem_rdata = bmem[mem_addr[11:2]];
  initial for (int i = 0; i < 1024; i++) bmem[i] = 32'hC0DE0000 + i;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        bmem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        if (rd_cnt % WORDS == 0) fill_base <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int stall = 0;
  always @(negedge clk) begin
    stall <= stall + 1;
    mem_ready <= (stall % 3) != 2;
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Arithmetic reference model
  bit          mv [0:WAYS-1][0:SETS-1];
  bit          md [0:WAYS-1][0:SETS-1];
  int          mt [0:WAYS-1][0:SETS-1];
  logic [31:0] mdat [0:WAYS-1][0:SETS-1][0:WORDS-1];
  int          mrr [0:SETS-1];
  logic [31:0] emem [0:SPAN-1];
  int          ehit = 0, emiss = 0, e_wr = 0;
  bit          e_hit;
  logic [31:0] e_rdata;

  initial begin
    for (int i = 0; i < SPAN; i++) emem[i] = 32'hC0DE0000 + i;
    for (int w = 0; w < WAYS; w++)
      for (int r = 0; r < SETS; r++) begin mv[w][r] = 0; md[w][r] = 0; mt[w][r] = 0; end
    for (int r = 0; r < SETS; r++) mrr[r] = 0;
  end

  task automatic model_access(input bit wr, input int wa, input logic [31:0] wd, input bit wbp);
    int tag, row, col, w;
    bit fnd;
    tag = wa / (WORDS * SETS); row = (wa / WORDS) % SETS; col = wa % WORDS;
    fnd = 0; w = 0;
    for (int i = 0; i < WAYS; i++)
      if (!fnd && (!mv[i][row] || mt[i][row] == tag)) begin fnd = 1; w = i; end
    if (!fnd) begin
      w = mrr[row];
      mrr[row] = (mrr[row] + 1) % WAYS;
      if (md[w][row] && wbp) begin
        for (int j = 0; j < WORDS; j++) emem[mt[w][row]*WORDS*SETS + row*WORDS + j] = mdat[w][row][j];
        e_wr += WORDS;
      end
      mv[w][row] = 0; md[w][row] = 0;
    end
    e_hit = mv[w][row];
    if (e_hit) ehit++;
    else begin
      emiss++;
      for (int j = 0; j < WORDS; j++) mdat[w][row][j] = emem[tag*WORDS*SETS + row*WORDS + j];
      mv[w][row] = 1; mt[w][row] = tag; md[w][row] = 0;
    end
    if (wr) begin
      mdat[w][row][col] = wd;
      if (wbp) md[w][row] = 1;
      else begin emem[wa] = wd; e_wr++; end
    end
    e_rdata = wr ? wd : mdat[w][row][col];
  endtask

  task automatic model_flush(input bit wbp);
    for (int w = 0; w < WAYS; w++)
      for (int r = 0; r < SETS; r++) begin
        if (mv[w][r] && md[w][r] && wbp) begin
          for (int j = 0; j < WORDS; j++) emem[mt[w][r]*WORDS*SETS + r*WORDS + j] = mdat[w][r][j];
          e_wr += WORDS;
        end
        mv[w][r] = 0; md[w][r] = 0;
      end
  endtask

  task automatic cpu_access(input bit wr, input int wa, input logic [31:0] wd);
    int rd0, wr0, ewr0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = wa * 4; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt; ewr0 = e_wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "req_ready while busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    model_access(wr, wa, wd, wb_policy);
    chk(e_hit ? "R5" : "R4", "response data", rsp_rdata, e_rdata);
    @(negedge clk);
    chk("R11", "rsp_valid single pulse", {31'd0, rsp_valid}, 32'd0);
    chk("R2", "hit_count", hit_count, ehit);
    chk("R3", "miss_count", miss_count, emiss);
    chk(e_hit ? "R5" : "R4", "fill reads", rd_cnt - rd0, e_hit ? 0 : WORDS);
    if (!e_hit) chk("R1", "fill base address", fill_base, (wa / WORDS) * WORDS * 4);
    chk(wb_policy ? "R6" : "R7", "memory writes", wr_cnt - wr0, e_wr - ewr0);
    if (wr && !wb_policy) chk("R7", "write-through word", bmem[wa], wd);
  endtask

  task automatic do_flush(input string req);
    int wr0, ewr0;
    wr0 = wr_cnt; ewr0 = e_wr;
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    chk("R11", "busy during flush", {31'd0, busy}, 32'd1);
    while (busy) @(negedge clk);
    model_flush(wb_policy);
    chk(req, "flush write count", wr_cnt - wr0, e_wr - ewr0);
    for (int i = 0; i < SPAN; i++) chk(req, "memory after flush", bmem[i], emem[i]);
  endtask

  task automatic run_ops(input int n, inout logic [15:0] lf);
    for (int k = 0; k < n; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cpu_access(lf[8], int'(lf[5:0]), {16'(k), lf});
    end
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "hit_count after reset", hit_count, 32'd0);
    chk("R10", "miss_count after reset", miss_count, 32'd0);
    chk("R11", "req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R11", "busy after reset", {31'd0, busy}, 32'd0);

    // Write-back phase: directed same-row conflicts, then a sweep
    cpu_access(1'b1, 0, 32'h11110000);
    cpu_access(1'b1, 16, 32'h22220010);
    cpu_access(1'b0, 32, '0);          // R3: evicts way 0 (dirty, R6)
    cpu_access(1'b0, 16, '0);          // R2: hit in way 1
    cpu_access(1'b0, 0, '0);           // R3: evicts way 1
    run_ops(300, lf);
    do_flush("R8");
    cpu_access(1'b0, 0, '0);           // R8: must miss after flush

    // Invalidate-all drops dirty data and clears statistics
    cpu_access(1'b1, 5, 32'hDEAD0005);
    @(negedge clk); inval_req = 1'b1;
    @(negedge clk); inval_req = 1'b0;
    for (int w = 0; w < WAYS; w++)
      for (int r = 0; r < SETS; r++) begin mv[w][r] = 0; md[w][r] = 0; end
    ehit = 0; emiss = 0;
    chk("R9", "hit_count after invalidate", hit_count, 32'd0);
    chk("R9", "miss_count after invalidate", miss_count, 32'd0);
    chk("R9", "memory untouched by invalidate", bmem[5], emem[5]);
    cpu_access(1'b0, 5, '0);
    chk("R9", "miss after invalidate", miss_count, 32'd1);

    // Write-through phase
    @(negedge clk); wb_policy = 1'b0;
    run_ops(200, lf);
    do_flush("R7");
    chk("R10", "total accesses counted", hit_count + miss_count, 32'd201);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule